// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block is the automation engine that sits behind a flash command decoder. The decoder hands it one-cycle requests to program a word or to erase a block. The engine maps the request address onto a 23-block array with the small blocks at the top. It refuses requests that hit a protected block, an address past the end of the array, or a low program supply. An accepted request runs for a parameterised number of clock cycles and then changes the stored data. The stored array is modelled in the block and can be read through a combinational port at any time.

A running erase can be paused so that the rest of the array can be read or other blocks can be programmed. A running program can be paused for reads only. A resume continues from the cycles left, not from the start. A power-down input aborts work in progress. It holds the busy indication for a fixed recovery time, then parks the engine until power-down is released. The engine then comes back idle with a clean status byte.

Top module: `flash_seq_top`

## Requirements
- R1: The word address space holds 15 large blocks of 2^MAIN_LG words from address 0 upward, then 6 small parameter blocks and 2 small boot blocks of 2^SMALL_LG words each, the two boot blocks being the highest. An accepted erase of any address in a block sets exactly that block's words to FFFFh and leaves every other word unchanged.
- R2: An accepted program stores the bitwise AND of the present word and the new data.
- R3: While wp_n is 0 and hv_rst is 0, an erase or program aimed at either boot block is refused. A refused erase sets status bit 5 and a refused program sets status bit 4. The data stays unchanged and ready stays 1. The refusal does not apply when hv_rst is 1, when wp_n is 1, or when the target is a non-boot block.
- R4: A request made while supply_ok is 0 is refused. Status bit 3 is set together with the request's error bit (bit 5 for erase, bit 4 for program), and the data stays unchanged.
- R5: After a request is accepted on a clock edge, ready is 0 for exactly ERASE_CYC cycles for an erase, or PROG_CYC cycles for a program, and then returns to 1.
- R6: The status byte is {ready, erase suspended, erase error, program error, supply low, program suspended, 0, 0}, MSB first. It reads 80h after reset and when idle with no errors. Bits 5, 4 and 3 hold until clr_status is pulsed.
- R7: susp_req during an erase gives ready 1 and status C0h on the next cycle. resume_req then completes the erase, and the total number of busy cycles is still ERASE_CYC.
- R8: While an erase is suspended, a program aimed at another block is accepted and runs for PROG_CYC cycles with status 40h. The engine then returns to the erase-suspended state. An erase request in this state is ignored.
- R9: While an erase is suspended, a program aimed at the suspended block is refused, status bit 4 is set and ready stays 1.
- R10: susp_req during a stand-alone program gives ready 1 and status 84h on the next cycle. Program and erase requests are ignored while the program is suspended. After resume the total number of busy cycles is PROG_CYC.
- R11: Raising pwr_dn while an operation runs aborts it, and ready stays 0 for ABORT_CYC cycles before it is released.
- R12: While pwr_dn is high the error bits are cleared. After pwr_dn falls, the status reads 80h and a new request is accepted normally.
- R13: Requests made while pwr_dn is high are ignored: no data change, no error bit, ready stays 1.
- R14: A request whose address is at or beyond the array depth is refused and sets the request's error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also fills the array with FFFFh |
| erase_req | input | 1 | One-cycle block erase request |
| prog_req | input | 1 | One-cycle word program request |
| op_addr | input | AW | Word address of the request |
| op_data | input | DW | Data for a program request |
| wp_n | input | 1 | Write-protect level; 0 locks the boot blocks |
| hv_rst | input | 1 | High-voltage reset level; overrides the boot lock |
| supply_ok | input | 1 | Program supply above lockout |
| susp_req | input | 1 | Suspend request |
| resume_req | input | 1 | Resume request |
| clr_status | input | 1 | Clears the sticky error bits |
| pwr_dn | input | 1 | Deep power-down / reset pin asserted |
| rd_addr | input | AW | Array read address |
| rd_data | output | DW | Array read data, FFFFh beyond the array |
| status | output | 8 | Status byte |
| ready | output | 1 | 0 while busy, 1 when idle, suspended or powered down |

## Verification
A wrong block decode shows up as words erased outside the target block, or target words left intact. Both are visible at rd_data one cycle after busy ends, so every erase is followed by a full read sweep. A timer that restarts on resume, or that loses a cycle on the suspend edge, changes the total count of busy cycles, so the bench counts them exactly. A state machine that mishandles nesting shows the wrong status byte one cycle after the request, or changes a word it should not have touched. That word is read back after the engine returns to idle.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int N_MAIN  = 15;
    localparam int N_PARAM = 6;
    localparam int N_BOOT  = 2;
    localparam int N_BLK   = N_MAIN + N_PARAM + N_BOOT;
    localparam int BLK_W   = $clog2(N_BLK);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ERASE,
        S_PROG,
        S_ESUSP,
        S_PSUSP,
        S_ESPROG,
        S_ABORT,
        S_PD
    } seq_state_t;

    function automatic int arr_depth(int main_lg, int small_lg);
        return (N_MAIN << main_lg) + ((N_PARAM + N_BOOT) << small_lg);
    endfunction

    function automatic int boot_base(int main_lg, int small_lg);
        return (N_MAIN << main_lg) + (N_PARAM << small_lg);
    endfunction

    // Block index of a word address; small blocks follow the large ones
    function automatic logic [BLK_W-1:0] blk_of(int a, int main_lg, int small_lg);
        int lim;
        lim = N_MAIN << main_lg;
        if (a < lim)
            return BLK_W'(a >> main_lg);
        return BLK_W'(N_MAIN + ((a - lim) >> small_lg));
    endfunction

endpackage

// File: rtl/flash_blk_map.sv
module flash_blk_map
    import flash_seq_pkg::*;
#(
    parameter int MAIN_LG  = 3,
    parameter int SMALL_LG = 1,
    parameter int AW       = 8
) (
    input  logic [AW-1:0]    addr,
    output logic [BLK_W-1:0] blk,
    output logic             valid,
    output logic             boot
);
    localparam int DEPTH = arr_depth(MAIN_LG, SMALL_LG);

    always_comb begin
        blk   = blk_of(int'(addr), MAIN_LG, SMALL_LG);
        valid = int'(addr) < DEPTH;
        boot  = valid && (int'(blk) >= N_MAIN + N_PARAM);
    end
endmodule

// File: rtl/flash_cyc_timer.sv
module flash_cyc_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (dec && cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array
    import flash_seq_pkg::*;
#(
    parameter int MAIN_LG  = 3,
    parameter int SMALL_LG = 1,
    parameter int AW       = 8,
    parameter int DW       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             erase_en,
    input  logic [BLK_W-1:0] erase_blk,
    input  logic             prog_en,
    input  logic [AW-1:0]    prog_addr,
    input  logic [DW-1:0]    prog_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data
);
    localparam int DEPTH = arr_depth(MAIN_LG, SMALL_LG);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst)
                mem[i] <= '1;
            else if (erase_en && blk_of(i, MAIN_LG, SMALL_LG) == erase_blk)
                mem[i] <= '1;
            else if (prog_en && prog_addr == AW'(i))
                mem[i] <= mem[i] & prog_data;
        end
    end

    assign rd_data = (rd_addr < AW'(DEPTH)) ? mem[rd_addr] : '1;
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
    import flash_seq_pkg::*;
#(
    parameter  int MAIN_LG   = 3,
    parameter  int SMALL_LG  = 1,
    parameter  int DW        = 16,
    parameter  int ERASE_CYC = 20,
    parameter  int PROG_CYC  = 6,
    parameter  int ABORT_CYC = 4,
    localparam int AW        = $clog2(arr_depth(MAIN_LG, SMALL_LG))
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          erase_req,
    input  logic          prog_req,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_data,
    input  logic          wp_n,
    input  logic          hv_rst,
    input  logic          supply_ok,
    input  logic          susp_req,
    input  logic          resume_req,
    input  logic          clr_status,
    input  logic          pwr_dn,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [7:0]    status,
    output logic          ready
);
    localparam int EW = $clog2(ERASE_CYC + 1);
    localparam int PW = $clog2(PROG_CYC + 1);
    localparam int XW = $clog2(ABORT_CYC + 1);

    seq_state_t       st, st_n;
    logic [AW-1:0]    p_addr;
    logic [DW-1:0]    p_data;
    logic [BLK_W-1:0] e_blk;
    logic             err_e, err_p, err_v;

    logic [BLK_W-1:0] req_blk;
    logic             req_valid, req_boot;
    logic             bad_common, p_bad;
    logic             e_load, p_load, a_load;
    logic             set_e, set_p, set_v;
    logic [EW-1:0]    e_cnt;
    logic [PW-1:0]    p_cnt;
    logic [XW-1:0]    a_cnt;
    logic             e_last, p_last, a_last;
    logic             busy_st;

    flash_blk_map #(.MAIN_LG(MAIN_LG), .SMALL_LG(SMALL_LG), .AW(AW)) map_i (
        .addr(op_addr), .blk(req_blk), .valid(req_valid), .boot(req_boot)
    );

    flash_cyc_timer #(.W(EW)) etmr_i (
        .clk(clk), .rst(rst), .clr(pwr_dn), .load(e_load), .val(EW'(ERASE_CYC)),
        .dec(st == S_ERASE), .cnt(e_cnt), .last(e_last)
    );

    flash_cyc_timer #(.W(PW)) ptmr_i (
        .clk(clk), .rst(rst), .clr(pwr_dn), .load(p_load), .val(PW'(PROG_CYC)),
        .dec(st == S_PROG || st == S_ESPROG), .cnt(p_cnt), .last(p_last)
    );

    flash_cyc_timer #(.W(XW)) atmr_i (
        .clk(clk), .rst(rst), .clr(1'b0), .load(a_load), .val(XW'(ABORT_CYC)),
        .dec(st == S_ABORT), .cnt(a_cnt), .last(a_last)
    );

    flash_seq_array #(.MAIN_LG(MAIN_LG), .SMALL_LG(SMALL_LG), .AW(AW), .DW(DW)) arr_i (
        .clk(clk), .rst(rst),
        .erase_en(st == S_ERASE && e_last && !pwr_dn), .erase_blk(e_blk),
        .prog_en((st == S_PROG || st == S_ESPROG) && p_last && !pwr_dn),
        .prog_addr(p_addr), .prog_data(p_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign busy_st    = (st == S_ERASE) || (st == S_PROG) || (st == S_ESPROG) || (st == S_ABORT);
    assign bad_common = !supply_ok || !req_valid || (req_boot && !wp_n && !hv_rst);
    assign p_bad      = bad_common || (st == S_ESUSP && req_blk == e_blk);

    always_comb begin
        st_n   = st;
        e_load = 1'b0;
        p_load = 1'b0;
        a_load = 1'b0;
        set_e  = 1'b0;
        set_p  = 1'b0;
        set_v  = 1'b0;
        if (st == S_ABORT) begin
            if (a_last || a_cnt == '0)
                st_n = pwr_dn ? S_PD : S_IDLE;
        end else if (pwr_dn) begin
            if (busy_st) begin
                st_n   = S_ABORT;
                a_load = 1'b1;
            end else begin
                st_n = S_PD;
            end
        end else begin
            case (st)
                S_IDLE: begin
                    if (erase_req) begin
                        if (bad_common) begin
                            set_e = 1'b1;
                            set_v = !supply_ok;
                        end else begin
                            st_n   = S_ERASE;
                            e_load = 1'b1;
                        end
                    end else if (prog_req) begin
                        if (p_bad) begin
                            set_p = 1'b1;
                            set_v = !supply_ok;
                        end else begin
                            st_n   = S_PROG;
                            p_load = 1'b1;
                        end
                    end
                end
                S_ERASE: begin
                    if (e_last)        st_n = S_IDLE;
                    else if (susp_req) st_n = S_ESUSP;
                end
                S_PROG: begin
                    if (p_last)        st_n = S_IDLE;
                    else if (susp_req) st_n = S_PSUSP;
                end
                S_ESUSP: begin
                    if (resume_req) begin
                        st_n = S_ERASE;
                    end else if (prog_req) begin
                        if (p_bad) begin
                            set_p = 1'b1;
                            set_v = !supply_ok;
                        end else begin
                            st_n   = S_ESPROG;
                            p_load = 1'b1;
                        end
                    end
                end
                S_PSUSP:  if (resume_req) st_n = S_PROG;
                S_ESPROG: if (p_last) st_n = S_ESUSP;
                S_PD:     st_n = S_IDLE;
                default:  st_n = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            p_addr <= '0;
            p_data <= '0;
            e_blk  <= '0;
            err_e  <= 1'b0;
            err_p  <= 1'b0;
            err_v  <= 1'b0;
        end else begin
            st <= st_n;
            if (p_load) begin
                p_addr <= op_addr;
                p_data <= op_data;
            end
            if (e_load)
                e_blk <= req_blk;
            if (pwr_dn || st == S_ABORT || st == S_PD) begin
                err_e <= 1'b0;
                err_p <= 1'b0;
                err_v <= 1'b0;
            end else begin
                err_e <= set_e || (err_e && !clr_status);
                err_p <= set_p || (err_p && !clr_status);
                err_v <= set_v || (err_v && !clr_status);
            end
        end
    end

    assign ready  = !busy_st;
    assign status = {ready, (st == S_ESUSP || st == S_ESPROG), err_e, err_p, err_v,
                     (st == S_PSUSP), 2'b00};
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk
    import flash_seq_pkg::*;
#(
    parameter int MAIN_LG  = 3,
    parameter int SMALL_LG = 1,
    parameter int AW       = 8,
    parameter int EW       = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          erase_req,
    input logic [AW-1:0] op_addr,
    input logic          wp_n,
    input logic          hv_rst,
    input logic          supply_ok,
    input logic          susp_req,
    input logic          resume_req,
    input logic          clr_status,
    input logic          pwr_dn,
    input logic [7:0]    status,
    input logic          ready,
    input seq_state_t    st,
    input logic [EW-1:0] ecnt
);
    localparam int DEPTH = arr_depth(MAIN_LG, SMALL_LG);
    localparam int BBASE = boot_base(MAIN_LG, SMALL_LG);

    AST_SUSPEND_PROMPT: assert property (@(posedge clk) disable iff (rst)
        (st == S_ERASE || st == S_PROG) && susp_req && !pwr_dn |=> ready); // R7

    AST_RESUME_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        st == S_ESUSP && resume_req && !pwr_dn |=> ecnt == $past(ecnt)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status & 8'h20) != 8'h00 && !clr_status && !pwr_dn && st != S_ABORT && st != S_PD
        |=> (status & 8'h20) != 8'h00); // R6

    AST_ABORT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        !ready && pwr_dn && st != S_ABORT |=> !ready); // R11

    AST_EXIT_PD_CLEAN: assert property (@(posedge clk) disable iff (rst)
        st == S_PD && !pwr_dn |=> status == 8'h80); // R12

    AST_BOOT_LOCK: assert property (@(posedge clk) disable iff (rst)
        st == S_IDLE && erase_req && !pwr_dn && !wp_n && !hv_rst &&
        op_addr >= AW'(BBASE) && op_addr < AW'(DEPTH)
        |=> ready && (status & 8'h20) != 8'h00); // R3

    AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (rst)
        st == S_IDLE && erase_req && !pwr_dn && !supply_ok
        |=> ready && (status & 8'h28) == 8'h28); // R4
endmodule

bind flash_seq_top flash_seq_chk #(
    .MAIN_LG(MAIN_LG), .SMALL_LG(SMALL_LG), .AW(AW), .EW(EW)
) chk_i (
    .clk(clk), .rst(rst), .erase_req(erase_req), .op_addr(op_addr),
    .wp_n(wp_n), .hv_rst(hv_rst), .supply_ok(supply_ok), .susp_req(susp_req),
    .resume_req(resume_req), .clr_status(clr_status), .pwr_dn(pwr_dn),
    .status(status), .ready(ready), .st(st), .ecnt(e_cnt)
);

// File: tb/flash_seq_top_tb_top.sv
module flash_seq_top_tb_top;
    localparam int MAIN_LG = 3, SMALL_LG = 1;
    localparam int MW = 8, SW = 2, DEPTH = 136, AW = 8;
    localparam int ECYC = 20, PCYC = 6, XCYC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic erase_req = 0, prog_req = 0, wp_n = 1, hv_rst = 0, supply_ok = 1;
    logic susp_req = 0, resume_req = 0, clr_status = 0, pwr_dn = 0;
    logic [AW-1:0] op_addr = '0, rd_addr = '0;
    logic [15:0]   op_data = '0, rd_data;
    logic [7:0]    status;
    logic          ready;
    logic [15:0]   model [DEPTH];
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    flash_seq_top #(.MAIN_LG(MAIN_LG), .SMALL_LG(SMALL_LG), .DW(16), .ERASE_CYC(ECYC),
                    .PROG_CYC(PCYC), .ABORT_CYC(XCYC)) dut_i (
        .clk(clk), .rst(rst), .erase_req(erase_req), .prog_req(prog_req),
        .op_addr(op_addr), .op_data(op_data), .wp_n(wp_n), .hv_rst(hv_rst),
        .supply_ok(supply_ok), .susp_req(susp_req), .resume_req(resume_req),
        .clr_status(clr_status), .pwr_dn(pwr_dn), .rd_addr(rd_addr),
        .rd_data(rd_data), .status(status), .ready(ready)
    );

    function automatic int tb_blk(int a);
        return (a < 15 * MW) ? a / MW : 15 + (a - 15 * MW) / SW;
    endfunction

    function automatic logic [15:0] pat(int a);
        return {a[7:0], ~a[7:0]};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go_erase(input int a);
        op_addr = AW'(a); erase_req = 1;
        @(negedge clk); erase_req = 0;
    endtask

    task automatic go_prog(input int a, input logic [15:0] d);
        op_addr = AW'(a); op_data = d; prog_req = 1;
        @(negedge clk); prog_req = 0;
    endtask

    task automatic pulse_clr();
        clr_status = 1; @(negedge clk); clr_status = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (!ready && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic read_chk(input string tag, input int a);
        rd_addr = AW'(a); #1;
        check(tag, int'(rd_data), int'(model[a]));
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < DEPTH; a++) read_chk(tag, a);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, m;
        for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R6 status after reset", status, 8'h80);
        check("R6 ready after reset", ready, 1);
        sweep("R1 erased after reset");

        // R2 / R5: program every word with its pattern
        for (int a = 0; a < DEPTH; a++) begin
            go_prog(a, pat(a));
            wait_idle(n);
            check("R5 program busy cycles", n, PCYC);
            model[a] &= pat(a);
        end
        sweep("R2 program pattern");
        go_prog(10, 16'hF00F); wait_idle(n);
        model[10] &= 16'hF00F;
        read_chk("R2 AND into word", 10);
        @(negedge clk);

        // R3 boot lock
        wp_n = 0; hv_rst = 0;
        go_erase(134);
        check("R3 locked erase ready", ready, 1);
        check("R3 locked erase status", status, 8'hA0);
        go_prog(133, 16'h0000);
        check("R3 locked program status", status, 8'hB0);
        read_chk("R3 boot word unchanged", 134);
        read_chk("R3 boot word unchanged", 133);
        @(negedge clk);
        pulse_clr();
        check("R6 clear errors", status, 8'h80);
        hv_rst = 1;
        go_prog(133, 16'h00FF); wait_idle(n);
        model[133] &= 16'h00FF;
        check("R3 hv override busy", n, PCYC);
        read_chk("R3 hv override data", 133);
        @(negedge clk);
        hv_rst = 0;
        go_prog(130, 16'h0F0F); wait_idle(n);
        model[130] &= 16'h0F0F;
        check("R3 param block not locked", n, PCYC);
        read_chk("R3 param block data", 130);
        @(negedge clk);
        wp_n = 1;

        // R4 supply low
        supply_ok = 0;
        go_erase(0);
        check("R4 erase refused", status, 8'hA8);
        go_prog(1, 16'h0000);
        check("R4 program refused", status, 8'hB8);
        check("R4 ready", ready, 1);
        read_chk("R4 data kept", 0);
        read_chk("R4 data kept", 1);
        @(negedge clk);
        supply_ok = 1;
        pulse_clr();
        check("R6 clear after R4", status, 8'h80);

        // R14 out of range
        go_prog(200, 16'h0000);
        check("R14 program out of range", status, 8'h90);
        go_erase(136);
        check("R14 erase out of range", status, 8'hB0);
        pulse_clr();

        // R1 block map: erase every block through its last word
        for (int b = 0; b < 23; b++) begin
            int base, size;
            base = (b < 15) ? b * MW : 15 * MW + (b - 15) * SW;
            size = (b < 15) ? MW : SW;
            go_erase(base + size - 1);
            wait_idle(n);
            check("R5 erase busy cycles", n, ECYC);
            for (int a = 0; a < DEPTH; a++) if (tb_blk(a) == b) model[a] = 16'hFFFF;
            sweep("R1 erase scope");
        end

        // R7 R8 R9 erase suspend
        go_prog(24, 16'h1234); wait_idle(n); model[24] = 16'h1234;
        go_prog(56, 16'h00F0); wait_idle(n); model[56] = 16'h00F0;
        go_erase(24);
        repeat (4) @(negedge clk);
        susp_req = 1; @(negedge clk); susp_req = 0;
        m = 5;
        check("R7 suspended ready", ready, 1);
        check("R7 suspended status", status, 8'hC0);
        go_prog(40, 16'h5A5A);
        check("R8 nested program status", status, 8'h40);
        wait_idle(n);
        model[40] &= 16'h5A5A;
        check("R8 nested program cycles", n, PCYC);
        check("R8 back to erase suspend", status, 8'hC0);
        read_chk("R8 nested program data", 40);
        @(negedge clk);
        go_erase(56);
        check("R8 erase ignored ready", ready, 1);
        check("R8 erase ignored status", status, 8'hC0);
        go_prog(25, 16'h0000);
        check("R9 same block refused", status, 8'hD0);
        check("R9 ready", ready, 1);
        resume_req = 1; @(negedge clk); resume_req = 0;
        wait_idle(n);
        check("R7 total erase cycles", m + n, ECYC);
        check("R6 error sticky", status, 8'h90);
        model[24] = 16'hFFFF;
        read_chk("R7 erase completed", 24);
        read_chk("R9 refused program", 25);
        read_chk("R8 ignored erase", 56);
        @(negedge clk);
        pulse_clr();
        check("R6 cleared", status, 8'h80);

        // R10 program suspend
        go_prog(72, 16'h3C3C);
        @(negedge clk);
        susp_req = 1; @(negedge clk); susp_req = 0;
        check("R10 suspended ready", ready, 1);
        check("R10 suspended status", status, 8'h84);
        go_prog(80, 16'h0000);
        check("R10 program ignored", status, 8'h84);
        go_erase(88);
        check("R10 erase ignored", status, 8'h84);
        resume_req = 1; @(negedge clk); resume_req = 0;
        wait_idle(n);
        check("R10 total program cycles", 2 + n, PCYC);
        model[72] = 16'h3C3C;
        read_chk("R10 program data", 72);
        read_chk("R10 ignored program", 80);
        @(negedge clk);
        check("R10 status after", status, 8'h80);

        // R11 R12 R13 power-down
        go_prog(8, 16'h1111); wait_idle(n); model[8] = 16'h1111;
        supply_ok = 0; go_erase(0); supply_ok = 1;
        check("R4 error before power-down", status, 8'hA8);
        go_prog(100, 16'h0000);
        @(negedge clk);
        pwr_dn = 1; @(negedge clk);
        wait_idle(n);
        check("R11 abort busy cycles", n, XCYC);
        check("R12 status in power-down", status, 8'h80);
        go_erase(8);
        check("R13 request ignored ready", ready, 1);
        check("R13 request ignored status", status, 8'h80);
        repeat (3) @(negedge clk);
        read_chk("R13 data kept", 8);
        @(negedge clk);
        pwr_dn = 0; @(negedge clk);
        check("R12 status after power-down", status, 8'h80);
        check("R12 ready after power-down", ready, 1);
        go_prog(8, 16'h0101); wait_idle(n);
        model[8] &= 16'h0101;
        check("R12 accepts after power-down", n, PCYC);
        read_chk("R12 data after power-down", 8);
        @(negedge clk);

        finish_run();
    end
endmodule